// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one management transaction at a time against an external Ethernet PHY. It uses a serial clock output and a data line that is split into an output value, an output enable and a sampled input. A host raises a one-cycle start strobe with a read/write select, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a control that suppresses the preamble. The block then shifts out the whole frame and, on a read, collects the PHY's 16-bit reply.

The management clock comes from the system clock through a divider. Its period is 2·(DIV+1) system clocks, and it rests low between frames. The outgoing bit changes only while the management clock is low, at the point where it falls. Read data is taken at each rising edge. While the block is working, `busy` is high and further start strobes are ignored. At the end, a one-cycle `done` pulse marks the point where `rd_data` holds the captured reply.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is running, `mdc` is low, `mdio_oe` is low (line released), `busy` and `done` are low, and after reset `rd_data` is 0.
- R2: A start strobe seen while idle raises `busy` on the next cycle. `busy` stays high for exactly N·2·(DIV+1) cycles, where N = 64 normally and N = 32 with `no_pre` set. `done` is high for exactly one cycle, the first cycle with `busy` low.
- R3: During a frame `mdc` completes exactly N rising edges, each high phase lasting DIV+1 system cycles and each low phase DIV+1 cycles.
- R4: Unless `no_pre` is 1, the frame opens with 32 bits of value 1, all driven (`mdio_oe`=1). With `no_pre`=1 no such bits are sent.
- R5: After the preamble come the start bits 0 then 1, followed by the operation bits: 1,0 when `rd_nwr`=1 (read) and 0,1 when `rd_nwr`=0 (write), all driven.
- R6: Then `phy_addr` and `reg_addr` follow, 5 bits each, most significant bit first, all driven.
- R7: On a write the two turnaround bits are driven as 1 then 0, followed by `wr_data` driven most significant bit first.
- R8: On a read `mdio_oe` is 0 for the two turnaround bits and all 16 data bits. `mdio_i` is sampled at each of the 16 data-bit rising edges of `mdc`, shifted in MSB first, and presented on `rd_data` from the `done` cycle on.
- R9: A start strobe while `busy` is high has no effect: the running frame's bits, length and read result are unchanged, and no second frame follows.
- R10: `mdio_o` and `mdio_oe` hold steady for as long as `mdc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a frame |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data sent on a write |
| no_pre | input | 1 | 1 omits the 32-bit preamble |
| rd_data | output | 16 | Data captured on the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line |

## Verification
The strobe is applied before a clock edge, and `busy` is due in the cycle that follows that edge. `busy` must then hold for exactly N·2·(DIV+1) sampled cycles, and `done` is expected in the first sample where `busy` is low, with `rd_data` checked in that same sample. Line bits are taken at each rising edge of `mdc`, the moment the PHY itself would use them. A PHY model changes `mdio_i` only at falling edges of `mdc`, so each read bit is stable well before the edge at which the master takes it. A cycle after `done` the bench checks that the block is idle again, which shows that a strobe issued in mid-frame started nothing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PRE  = 2'd1,
      SQ_BODY = 2'd2
   } seq_st_t;

   localparam logic [1:0] SOF_CODE  = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] TA_WRITE  = 2'b10;
   localparam logic [1:0] TA_READ   = 2'b11;
   localparam int         TA_BITS   = 2;
   localparam int         FIXED_HDR = 4;   // start + opcode bits
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic fall_evt
);
   logic evt;

   generate
      if (DIV == 0) begin : g_nodiv
         assign evt = run;
      end else begin : g_div
         localparam int CW = $clog2(DIV + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt <= '0;
            else if (!run || cnt == CW'(DIV))  cnt <= '0;
            else                               cnt <= cnt + CW'(1);
         end
         assign evt = run && (cnt == CW'(DIV));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mdc <= 1'b0;
      else if (!run) mdc <= 1'b0;
      else if (evt)  mdc <= ~mdc;
   end

   assign rise_evt = evt & ~mdc;
   assign fall_evt = evt &  mdc;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_nwr,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              no_pre,
   input  logic              fall_evt,
   output logic              busy,
   output logic              done,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              data_phase,
   output logic              rd_op
);
   localparam int HDR_LEN  = FIXED_HDR + PHY_AW + REG_AW;
   localparam int DATA_POS = HDR_LEN + TA_BITS;
   localparam int BODY_LEN = DATA_POS + DATA_W;
   localparam int MAX_LEN  = (PRE_LEN > BODY_LEN) ? PRE_LEN : BODY_LEN;
   localparam int CW       = $clog2(MAX_LEN + 1);

   seq_st_t             st;
   logic [CW-1:0]       cnt;
   logic [BODY_LEN-1:0] shreg;
   logic                is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         cnt   <= '0;
         shreg <= '0;
         is_rd <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  st    <= no_pre ? SQ_BODY : SQ_PRE;
                  cnt   <= '0;
                  is_rd <= rd_nwr;
                  shreg <= {SOF_CODE, (rd_nwr ? OPC_READ : OPC_WRITE),
                            phy_addr, reg_addr,
                            (rd_nwr ? TA_READ : TA_WRITE),
                            (rd_nwr ? {DATA_W{1'b0}} : wr_data)};
               end
            end
            SQ_PRE: begin
               if (fall_evt) begin
                  if (cnt == CW'(PRE_LEN - 1)) begin
                     st  <= SQ_BODY;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
            end
            SQ_BODY: begin
               if (fall_evt) begin
                  if (cnt == CW'(BODY_LEN - 1)) begin
                     st   <= SQ_IDLE;
                     cnt  <= '0;
                     done <= 1'b1;
                  end else begin
                     cnt   <= cnt + CW'(1);
                     shreg <= {shreg[BODY_LEN-2:0], 1'b0};
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy       = (st != SQ_IDLE);
   assign mdio_o     = (st == SQ_PRE) | ((st == SQ_BODY) & shreg[BODY_LEN-1]);
   assign mdio_oe    = (st == SQ_PRE) |
                       ((st == SQ_BODY) & (!is_rd | (cnt < CW'(HDR_LEN))));
   assign data_phase = (st == SQ_BODY) & (cnt >= CW'(DATA_POS));
   assign rd_op      = is_rd;
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_evt,
   input  logic              data_phase,
   input  logic              rd_op,
   input  logic              mdio_i,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rise_evt && data_phase && rd_op)
         rd_data <= {rd_data[DATA_W-2:0], mdio_i};
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int DIV     = 1,
   parameter int PRE_LEN = 32,
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_nwr,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              no_pre,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   initial begin
      assert (DIV >= 0)     else $error("DIV must not be negative");
      assert (PRE_LEN >= 1) else $error("PRE_LEN must be at least 1");
      assert (PHY_AW >= 1 && REG_AW >= 1) else $error("address widths must be positive");
      assert (DATA_W >= 2)  else $error("DATA_W must be at least 2");
   end

   logic rise_evt, fall_evt, data_phase, rd_op;

   mdio_clkgen #(.DIV(DIV)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_frame_seq #(
      .PRE_LEN (PRE_LEN),
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rd_nwr     (rd_nwr),
      .phy_addr   (phy_addr),
      .reg_addr   (reg_addr),
      .wr_data    (wr_data),
      .no_pre     (no_pre),
      .fall_evt   (fall_evt),
      .busy       (busy),
      .done       (done),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .data_phase (data_phase),
      .rd_op      (rd_op)
   );

   mdio_rx_shift #(.DATA_W(DATA_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_evt   (rise_evt),
      .data_phase (data_phase),
      .rd_op      (rd_op),
      .mdio_i     (mdio_i),
      .rd_data    (rd_data)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DIV = 1
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   localparam int HW = $clog2(DIV + 3);
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_cnt <= '0;
      else if (mdc) hi_cnt <= hi_cnt + HW'(1);
      else          hi_cnt <= '0;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));

   p_high_phase_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (hi_cnt == HW'(DIV + 1)));

   p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) && !$past(busy)));

   p_steady_while_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_nwr = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic        no_pre = 1'b0;
   logic [15:0] rd_data;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   // line monitor and PHY model state
   logic [63:0] cap_v = '0;
   logic [63:0] cap_oe = '0;
   int          rise_n = 0;
   logic        phy_rd = 1'b0;
   logic        phy_np = 1'b0;
   logic [15:0] phy_val = '0;

   mdio_master #(.DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
      .no_pre(no_pre), .rd_data(rd_data), .busy(busy), .done(done),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #2.5 clk = ~clk;

   always @(posedge mdc) begin
      cap_v  = {cap_v[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe};
      rise_n = rise_n + 1;
   end

   // PHY drives the bit for the next rising edge after each falling edge
   always @(negedge mdc) begin
      int b;
      b = rise_n - (phy_np ? 0 : 32);
      if (phy_rd && b == 15)                 mdio_i = 1'b0;
      else if (phy_rd && b >= 16 && b < 32)  mdio_i = phy_val[31-b];
      else                                   mdio_i = 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_val(logic rd, logic [4:0] pa, logic [4:0] ra,
                                           logic [15:0] wd, logic np);
      logic [31:0] body;
      body = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : wd)};
      return np ? {32'h0, body} : {32'hFFFF_FFFF, body};
   endfunction

   function automatic logic [63:0] exp_oe(logic rd, logic np);
      logic [31:0] m;
      m = rd ? 32'hFFFC_0000 : 32'hFFFF_FFFF;
      return np ? {32'h0, m} : {32'hFFFF_FFFF, m};
   endfunction

   task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] rv,
                            input logic np, input bit inject);
      int n, len, hi;
      logic [63:0] ev, eo, mv, mo;
      n = np ? 32 : 64;
      @(negedge clk);
      cap_v = '0; cap_oe = '0; rise_n = 0;
      phy_rd = rd; phy_np = np; phy_val = rv; mdio_i = 1'b1;
      rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; no_pre = np;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      len = 0; hi = 0;
      while (busy && len < 5000) begin
         len++;
         if (mdc) hi++;
         if (inject && len == 40) begin
            start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra;
            wr_data = ~wd; no_pre = ~np;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(len == n*2*(DIV+1), "R2 busy length", 64'(len), 64'(n*2*(DIV+1)));
      chk(done == 1'b1, "R2 done after busy", 64'(done), 64'd1);
      chk(rise_n == n, "R3 mdc rising edges", 64'(rise_n), 64'(n));
      chk(hi == n*(DIV+1), "R3 mdc high cycles", 64'(hi), 64'(n*(DIV+1)));
      ev = exp_val(rd, pa, ra, wd, np);
      eo = exp_oe(rd, np);
      mv = cap_v & eo;
      mo = ev & eo;
      chk(cap_oe[63:32] == eo[63:32] && mv[63:32] == mo[63:32], "R4 preamble",
          {cap_oe[63:32], cap_v[63:32]}, {eo[63:32], ev[63:32]});
      chk(cap_oe[31:28] == 4'hF && cap_v[31:28] == ev[31:28], "R5 start/opcode",
          64'(cap_v[31:28]), 64'(ev[31:28]));
      chk(cap_oe[27:18] == 10'h3FF && cap_v[27:18] == ev[27:18], "R6 addresses",
          64'(cap_v[27:18]), 64'(ev[27:18]));
      if (rd) begin
         chk(cap_oe[17:0] == 18'h0, "R8 line released", 64'(cap_oe[17:0]), 64'h0);
         chk(rd_data == rv, "R8 read data", 64'(rd_data), 64'(rv));
      end else begin
         chk(cap_oe[17:0] == 18'h3FFFF && cap_v[17:0] == ev[17:0], "R7 turnaround/data",
             64'(cap_v[17:0]), 64'(ev[17:0]));
      end
      @(negedge clk);
      chk(done == 1'b0, "R2 done one cycle", 64'(done), 64'd0);
      chk(!busy && !mdc && !mdio_oe, inject ? "R9 no second frame" : "R1 idle after frame",
          {61'd0, busy, mdc, mdio_oe}, 64'd0);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mdc && !mdio_oe && rd_data == 16'h0, "R1 reset state",
          {43'd0, busy, done, mdc, mdio_oe, rd_data}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !mdc && !mdio_oe, "R1 idle after reset", {61'd0, busy, mdc, mdio_oe}, 64'd0);

      // directed corner cases
      run_frame(1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0,    1'b0, 1'b0);
      run_frame(1'b1, 5'h00, 5'h1F, 16'h0,    16'h8001, 1'b0, 1'b0);
      run_frame(1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0,    1'b1, 1'b0);
      run_frame(1'b1, 5'h0A, 5'h15, 16'h0,    16'h7FFE, 1'b1, 1'b0);
      run_frame(1'b1, 5'h03, 5'h11, 16'h0,    16'h1234, 1'b0, 1'b1);   // R9 injected start
      run_frame(1'b0, 5'h1C, 5'h02, 16'h0001, 16'h0,    1'b1, 1'b1);   // R9 injected start

      // constrained random frames
      for (int i = 0; i < 14; i++) begin
         run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                   16'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule